// File: doc/BRIEF.md
# Graphics Command Word Sequencer

This block sits between a CPU or DMA write port and the drawing engine of a graphics unit. It takes 32-bit command words into a small buffer. From the top byte of each first word it works out how many words the command occupies, and it consumes the remaining words as they arrive. Once a command is complete it reports the command as retired on a one-cycle done strobe with its opcode.

A five-state sequencer (idle, collecting parameters, executing, streaming pixels out of video memory, streaming pixels into video memory) drives three status flags. These flags tell the host whether a new command, more DMA data, or a read of pixel data is expected. The flags follow the sequencer state, not the fill level of the buffer. For a pixel upload the length depends on the rectangle size carried in the third word. For a pixel readback the sequencer parks until the read engine signals the end of the transfer, and holds back any commands buffered behind it. A separate control port can flush everything back to idle.

Top module: `gp_cmd_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, the sequencer is idle (`seq_state` encoding: 0 idle, 1 collecting parameters, 2 executing, 3 reading video memory, 4 writing video memory), `gp0_ready`, `stat_cmd_ready` and `stat_dma_ready` are 1, and `stat_vram_send` and `cmd_done` are 0.
- R2: The opcode is bits 31:24 of a command's first word. Any opcode other than 0x02 and 0x80–0xDF is a single-word command: it is retired from idle on `cmd_done` one cycle after it is taken from the buffer, and the state stays idle. Commands retire in arrival order, each exactly once.
- R3: Opcode 0x02 (rectangle fill) occupies 3 words, 0x80–0x9F (memory-to-memory copy) 4 words, and 0xC0–0xDF (readback) 3 words. None retires before its last word is consumed.
- R4: Opcodes 0xA0–0xBF (pixel upload) occupy 3 + ceil(W*H/2) words. W is bits 9:0 of word 2, with 0 read as 1024. H is bits 24:16 of word 2, with 0 read as 512. Once word 2 is consumed, the state is 4 and `xfer_w`/`xfer_h` show W and H until the last word.
- R5: A multi-word command still short of words sits in state 1 (or 4 for an upload). After its last word is consumed, it spends exactly one cycle in state 2, then retires on `cmd_done`.
- R6: `stat_cmd_ready` is 1 only in state 0 and `stat_vram_send` only in state 3. `stat_dma_ready` is 1 in state 0, and in states 1 and 4 while a word count is outstanding; it is 0 in states 2 and 3.
- R7: A readback retires on entering state 3. `xfer_x` = word 1 bits 9:0, `xfer_y` = word 1 bits 25:16, and `xfer_w`/`xfer_h` are decoded as in R4. No buffered word is consumed until `rd_done` is pulsed, which returns the state to 0 so that buffered commands then run.
- R8: A control word with bits 31:24 = 0x01 returns the state to 0 on the next clock. It clears the outstanding count and the transfer outputs, and discards every buffered word and any word offered in the same cycle. Any other control code has no effect.
- R9: `gp0_ready` is 0 while `FIFO_DEPTH` words are buffered, and a word offered while it is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gp0_valid | input | 1 | Command word offered |
| gp0_data | input | 32 | Command word |
| gp0_ready | output | 1 | Buffer has room |
| ctl_valid | input | 1 | Control word strobe |
| ctl_data | input | 32 | Control word, code in bits 31:24 |
| rd_done | input | 1 | Read engine finished the readback rectangle |
| cmd_done | output | 1 | One-cycle retirement strobe |
| cmd_opcode | output | 8 | Opcode of the retired command |
| seq_state | output | 3 | Sequencer state code |
| stat_cmd_ready | output | 1 | Ready for a new command |
| stat_dma_ready | output | 1 | Ready for DMA words |
| stat_vram_send | output | 1 | Pixel readback in progress |
| xfer_x | output | 10 | Transfer rectangle left edge |
| xfer_y | output | 10 | Transfer rectangle top edge |
| xfer_w | output | 11 | Transfer rectangle width, 1..1024 |
| xfer_h | output | 10 | Transfer rectangle height, 1..512 |

## Verification
A word accepted at clock edge n is taken from the buffer at edge n+1. A single-word command therefore shows `cmd_done` after edge n+1. For a multi-word command whose last word lands at edge n, the state reads 2 after edge n+1, and retirement (or entry to state 3 for a readback) follows after edge n+2. A `rd_done` or clear at edge n shows state 0 after that same edge. The bench drives on falling edges and checks state and flags at the exact falling edge where each result is due. A scoreboard queue, filled when a command is sent, checks every `cmd_done` strobe for order, for opcode, and for not being spurious.

// File: rtl/gp_seq_pkg.sv
// Shared constants and types for the graphics command word sequencer.
// Assumes 32-bit command words with the opcode in the top byte.
package gp_seq_pkg;

    localparam int WORD_W     = 32;
    localparam int OP_W       = 8;
    localparam int COORD_BITS = 10;               // x / y coordinate field width
    localparam int WFLD_BITS  = 10;               // rectangle width field
    localparam int HFLD_BITS  = 9;                // rectangle height field
    localparam int PIX_W      = WFLD_BITS + HFLD_BITS + 2;
    localparam int CNT_W      = PIX_W;            // word counter width

    localparam logic [OP_W-1:0] CTL_FLUSH = 8'h01;
    localparam logic [OP_W-1:0] OP_FILL   = 8'h02;
    localparam logic [2:0] GRP_COPY   = 3'b100;
    localparam logic [2:0] GRP_UPLOAD = 3'b101;
    localparam logic [2:0] GRP_READ   = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_EXEC  = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        CL_SINGLE,
        CL_FILL,
        CL_COPY,
        CL_UPLOAD,
        CL_READ
    } cmd_class_t;

endpackage

// File: rtl/gp_cmd_fifo.sv
// Command word buffer: circular store of DEPTH words with a valid/ready
// write side and a show-ahead read side. Flush empties it in one cycle
// and wins over a write in the same cycle. Assumes DEPTH >= 2.
module gp_cmd_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push, take;

    assign in_ready = (count != CW'(DEPTH));
    assign empty    = (count == '0);
    assign push     = in_valid && in_ready && !flush;
    assign take     = pop && !empty && !flush;
    assign head     = mem[rd_ptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Advance pointers and occupancy; flush clears all three.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (take) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !pop && !flush) |=> !in_ready);
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/gp_cmd_decode.sv
// Command length decoder: classifies an opcode and derives the word
// count; for uploads, also decodes the rectangle size word (zero fields
// mean the maximum) and the resulting total length. Purely combinational.
module gp_cmd_decode
    import gp_seq_pkg::*;
(
    input  logic [OP_W-1:0]    op,
    input  logic [WORD_W-1:0]  size_word,
    output cmd_class_t         cls,
    output logic [CNT_W-1:0]   base_len,
    output logic [WFLD_BITS:0] rect_w,
    output logic [HFLD_BITS:0] rect_h,
    output logic [CNT_W-1:0]   upload_len
);
    logic [PIX_W-1:0] pix;
    logic [PIX_W-1:0] half;

    // Class and fixed word count from the opcode.
    always_comb begin
        cls      = CL_SINGLE;
        base_len = CNT_W'(1);
        if (op == OP_FILL) begin
            cls      = CL_FILL;
            base_len = CNT_W'(3);
        end else begin
            case (op[7:5])
                GRP_COPY:   begin cls = CL_COPY;   base_len = CNT_W'(4); end
                GRP_UPLOAD: begin cls = CL_UPLOAD; base_len = CNT_W'(3); end
                GRP_READ:   begin cls = CL_READ;   base_len = CNT_W'(3); end
                default:    begin cls = CL_SINGLE; base_len = CNT_W'(1); end
            endcase
        end
    end

    // Rectangle size with zero meaning full span, and the upload length.
    always_comb begin
        rect_w = (size_word[WFLD_BITS-1:0] == '0)
               ? {1'b1, {WFLD_BITS{1'b0}}} : {1'b0, size_word[WFLD_BITS-1:0]};
        rect_h = (size_word[16 +: HFLD_BITS] == '0)
               ? {1'b1, {HFLD_BITS{1'b0}}} : {1'b0, size_word[16 +: HFLD_BITS]};
        pix        = PIX_W'(rect_w) * PIX_W'(rect_h);
        half       = (pix + PIX_W'(1)) >> 1;
        upload_len = CNT_W'(half) + CNT_W'(3);
    end

endmodule

// File: rtl/gp_seq_status.sv
// Status flag generator: turns the sequencer state and the
// outstanding-count indication into the three host-visible flags.
module gp_seq_status
    import gp_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       count_pending,
    output logic       cmd_rdy,
    output logic       dma_rdy,
    output logic       vram_send
);
    // Flags follow the state only, never the buffer level.
    always_comb begin
        cmd_rdy   = (state == ST_IDLE);
        vram_send = (state == ST_READ);
        dma_rdy   = (state == ST_IDLE) || ((state != ST_READ) && count_pending);
    end

endmodule

// File: rtl/gp_cmd_sequencer.sv
// Graphics command word sequencer (top). Pulls words from the buffer,
// tracks how many words the current command still needs, retires
// commands on a done/opcode strobe, and parks in the readback state until
// the read engine reports completion. Assumes one word consumed per cycle
// at most; a control flush has priority over everything else.
module gp_cmd_sequencer
    import gp_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gp0_valid,
    input  logic [31:0]           gp0_data,
    output logic                  gp0_ready,
    input  logic                  ctl_valid,
    input  logic [31:0]           ctl_data,
    input  logic                  rd_done,
    output logic                  cmd_done,
    output logic [7:0]            cmd_opcode,
    output logic [2:0]            seq_state,
    output logic                  stat_cmd_ready,
    output logic                  stat_dma_ready,
    output logic                  stat_vram_send,
    output logic [9:0]            xfer_x,
    output logic [9:0]            xfer_y,
    output logic [10:0]           xfer_w,
    output logic [9:0]            xfer_h
);
    seq_state_t              state;
    cmd_class_t              cur_cls, dec_cls;
    logic [OP_W-1:0]         cur_op, done_op, dec_op;
    logic [CNT_W-1:0]        need, got;
    logic [CNT_W-1:0]        dec_base, dec_upload;
    logic [WFLD_BITS:0]      dec_w, x_w;
    logic [HFLD_BITS:0]      dec_h, x_h;
    logic [COORD_BITS-1:0]   x_x, x_y;
    logic [WORD_W-1:0]       head;
    logic                    empty, pop, can_pop, flush, done_q;

    assign flush   = ctl_valid && (ctl_data[31:24] == CTL_FLUSH);
    assign can_pop = (state == ST_IDLE) || (state == ST_WAIT) || (state == ST_WRITE);
    assign pop     = can_pop && !empty && !flush;
    assign dec_op  = (state == ST_IDLE) ? head[31:24] : cur_op;

    gp_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .in_valid (gp0_valid),
        .in_data  (gp0_data),
        .in_ready (gp0_ready),
        .pop      (pop),
        .head     (head),
        .empty    (empty)
    );

    gp_cmd_decode u_dec (
        .op         (dec_op),
        .size_word  (head),
        .cls        (dec_cls),
        .base_len   (dec_base),
        .rect_w     (dec_w),
        .rect_h     (dec_h),
        .upload_len (dec_upload)
    );

    gp_seq_status u_stat (
        .state         (state),
        .count_pending (need != '0),
        .cmd_rdy       (stat_cmd_ready),
        .dma_rdy       (stat_dma_ready),
        .vram_send     (stat_vram_send)
    );

    // Sequencer: state, word counting, transfer capture and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_cls <= CL_SINGLE;
            cur_op  <= '0;
            done_op <= '0;
            done_q  <= 1'b0;
            need    <= '0;
            got     <= '0;
            x_x     <= '0;
            x_y     <= '0;
            x_w     <= '0;
            x_h     <= '0;
        end else begin
            done_q <= 1'b0;
            if (flush) begin
                state <= ST_IDLE;
                need  <= '0;
                got   <= '0;
                x_x   <= '0;
                x_y   <= '0;
                x_w   <= '0;
                x_h   <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (pop) begin
                            cur_op  <= head[31:24];
                            cur_cls <= dec_cls;
                            if (dec_base == CNT_W'(1)) begin
                                done_q  <= 1'b1;
                                done_op <= head[31:24];
                            end else begin
                                need  <= dec_base;
                                got   <= CNT_W'(1);
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_WAIT, ST_WRITE: begin
                        if (pop) begin
                            got <= got + 1'b1;
                            if (got == CNT_W'(1)) begin
                                x_x <= head[COORD_BITS-1:0];
                                x_y <= head[16 +: COORD_BITS];
                            end
                            if (got == CNT_W'(2)) begin
                                x_w <= dec_w;
                                x_h <= dec_h;
                            end
                            if (cur_cls == CL_UPLOAD && got == CNT_W'(2)) begin
                                need  <= dec_upload;
                                state <= ST_WRITE;
                            end else if (got + 1'b1 == need) begin
                                need  <= '0;
                                state <= ST_EXEC;
                            end
                        end
                    end
                    ST_EXEC: begin
                        done_q  <= 1'b1;
                        done_op <= cur_op;
                        got     <= '0;
                        if (cur_cls == CL_READ) begin
                            state <= ST_READ;
                        end else begin
                            state <= ST_IDLE;
                            x_x   <= '0;
                            x_y   <= '0;
                            x_w   <= '0;
                            x_h   <= '0;
                        end
                    end
                    ST_READ: begin
                        if (rd_done) begin
                            state <= ST_IDLE;
                            x_x   <= '0;
                            x_y   <= '0;
                            x_w   <= '0;
                            x_h   <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign cmd_done   = done_q;
    assign cmd_opcode = done_op;
    assign seq_state  = state;
    assign xfer_x     = x_x;
    assign xfer_y     = x_y;
    assign xfer_w     = x_w;
    assign xfer_h     = x_h;

    p_done_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(state) == ST_IDLE || $past(state) == ST_EXEC));
    p_write_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> (need >= CNT_W'(4)));
    p_exec_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !flush) |=> (state != ST_EXEC));
    p_wait_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (need > got));
    p_read_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !rd_done && !flush) |=> (state == ST_READ && !done_q));
    p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_IDLE && need == '0 && !stat_vram_send));

endmodule

// File: tb/gp_cmd_sequencer_test.sv
module gp_cmd_sequencer_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gp0_valid = 1'b0;
    logic [31:0] gp0_data = '0;
    logic        gp0_ready;
    logic        ctl_valid = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        rd_done = 1'b0;
    logic        cmd_done;
    logic [7:0]  cmd_opcode;
    logic [2:0]  seq_state;
    logic        stat_cmd_ready, stat_dma_ready, stat_vram_send;
    logic [9:0]  xfer_x, xfer_y, xfer_h;
    logic [10:0] xfer_w;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    gp_cmd_sequencer #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .gp0_valid(gp0_valid), .gp0_data(gp0_data), .gp0_ready(gp0_ready),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .rd_done(rd_done),
        .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .seq_state(seq_state),
        .stat_cmd_ready(stat_cmd_ready), .stat_dma_ready(stat_dma_ready),
        .stat_vram_send(stat_vram_send),
        .xfer_x(xfer_x), .xfer_y(xfer_y), .xfer_w(xfer_w), .xfer_h(xfer_h)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: offer one word, return at the falling edge after acceptance.
    task automatic put_word(input logic [31:0] w);
        while (!gp0_ready) @(negedge clk);
        gp0_valid = 1'b1;
        gp0_data  = w;
        @(negedge clk);
        gp0_valid = 1'b0;
    endtask

    task automatic send_ctl(input logic [31:0] w);
        ctl_valid = 1'b1;
        ctl_data  = w;
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic pulse_rd_done();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    // Monitor: every retirement must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && cmd_done) begin
            if (exp_q.size() == 0) begin
                chk("R2", "unexpected retirement opcode", int'(cmd_opcode), -1);
            end else begin
                chk("R2", "retired opcode order", int'(cmd_opcode), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1", "state in reset", int'(seq_state), 0);
        chk("R1", "cmd_done in reset", int'(cmd_done), 0);
        rst_n = 1'b1;
        chk("R1", "state after reset", int'(seq_state), 0);
        chk("R1", "gp0_ready", int'(gp0_ready), 1);
        chk("R6", "cmd_ready idle", int'(stat_cmd_ready), 1);
        chk("R6", "dma_ready idle", int'(stat_dma_ready), 1);
        chk("R6", "vram_send idle", int'(stat_vram_send), 0);

        // R2: single-word latency
        exp_q.push_back(8'hE3);
        put_word(32'hE300_0011);
        chk("R2", "done not yet", int'(cmd_done), 0);
        tick(1);
        chk("R2", "done after pop", int'(cmd_done), 1);
        chk("R2", "opcode", int'(cmd_opcode), 'hE3);
        chk("R2", "state stays idle", int'(seq_state), 0);

        // R2: back-to-back singles and an unknown opcode
        exp_q.push_back(8'h00); put_word(32'h0000_0000);
        exp_q.push_back(8'h1F); put_word(32'h1F00_0000);
        exp_q.push_back(8'h55); put_word(32'h5500_0000);
        exp_q.push_back(8'hE1); put_word(32'hE100_0123);
        tick(3);
        chk("R2", "idle after singles", int'(seq_state), 0);

        // R3/R5/R6: fill, 3 words
        exp_q.push_back(8'h02);
        put_word(32'h0200_FFFF);
        tick(1);
        chk("R5", "fill waiting", int'(seq_state), 1);
        chk("R6", "cmd_ready in wait", int'(stat_cmd_ready), 0);
        chk("R6", "dma_ready in wait", int'(stat_dma_ready), 1);
        put_word(32'h0001_0001);
        tick(3);
        chk("R3", "fill still waiting", int'(seq_state), 1);
        put_word(32'h0004_0004);
        chk("R5", "fill last word buffered", int'(seq_state), 1);
        tick(1);
        chk("R5", "fill exec", int'(seq_state), 2);
        chk("R6", "dma_ready in exec", int'(stat_dma_ready), 0);
        chk("R6", "cmd_ready in exec", int'(stat_cmd_ready), 0);
        tick(1);
        chk("R5", "fill retired", int'(cmd_done), 1);
        chk("R5", "fill back to idle", int'(seq_state), 0);

        // R3: copy, 4 words
        exp_q.push_back(8'h80);
        put_word(32'h8000_0000);
        put_word(32'h0000_0000);
        put_word(32'h0010_0010);
        tick(3);
        chk("R3", "copy waits for 4th word", int'(seq_state), 1);
        put_word(32'h0002_0002);
        tick(1);
        chk("R3", "copy exec", int'(seq_state), 2);
        tick(1);
        chk("R3", "copy retired", int'(cmd_done), 1);

        // R7: readback parks and holds buffered commands
        exp_q.push_back(8'hC0);
        put_word(32'hC000_0000);
        put_word(32'h0007_0005);
        put_word(32'h0002_0003);
        tick(1);
        chk("R5", "read exec", int'(seq_state), 2);
        tick(1);
        chk("R7", "read state", int'(seq_state), 3);
        chk("R7", "read retired", int'(cmd_done), 1);
        chk("R6", "vram_send", int'(stat_vram_send), 1);
        chk("R6", "cmd_ready in read", int'(stat_cmd_ready), 0);
        chk("R6", "dma_ready in read", int'(stat_dma_ready), 0);
        chk("R7", "xfer_x", int'(xfer_x), 5);
        chk("R7", "xfer_y", int'(xfer_y), 7);
        chk("R7", "xfer_w", int'(xfer_w), 3);
        chk("R7", "xfer_h", int'(xfer_h), 2);
        exp_q.push_back(8'hE2);
        put_word(32'hE200_0000);
        tick(5);
        chk("R7", "still parked", int'(seq_state), 3);
        chk("R7", "held command not run", int'(cmd_done), 0);
        pulse_rd_done();
        chk("R7", "idle after rd_done", int'(seq_state), 0);
        chk("R7", "xfer cleared", int'(xfer_w), 0);
        tick(1);
        chk("R7", "held command runs", int'(cmd_done), 1);

        // R4: upload 3x3 -> 3 + 5 words
        exp_q.push_back(8'hA0);
        put_word(32'hA000_0000);
        put_word(32'h0000_0000);
        put_word(32'h0003_0003);
        tick(1);
        chk("R4", "upload state", int'(seq_state), 4);
        chk("R4", "upload w", int'(xfer_w), 3);
        chk("R4", "upload h", int'(xfer_h), 3);
        chk("R6", "dma_ready in write", int'(stat_dma_ready), 1);
        chk("R6", "cmd_ready in write", int'(stat_cmd_ready), 0);
        for (int i = 0; i < 4; i++) put_word(32'h1111_0000 + i);
        tick(3);
        chk("R4", "upload short one word", int'(seq_state), 4);
        put_word(32'h2222_2222);
        tick(1);
        chk("R4", "upload exec", int'(seq_state), 2);
        tick(1);
        chk("R4", "upload retired", int'(cmd_done), 1);

        // R4: zero width means 1024 -> 3 + 512 words
        exp_q.push_back(8'hA5);
        put_word(32'hA500_0000);
        put_word(32'h0000_0000);
        put_word(32'h0001_0000);
        tick(1);
        chk("R4", "w zero decodes 1024", int'(xfer_w), 1024);
        chk("R4", "h one", int'(xfer_h), 1);
        for (int i = 0; i < 511; i++) put_word(32'h0);
        tick(2);
        chk("R4", "1024-wide upload short one word", int'(seq_state), 4);
        put_word(32'h0);
        tick(1);
        chk("R4", "wide upload exec", int'(seq_state), 2);
        tick(1);
        chk("R4", "wide upload retired", int'(cmd_done), 1);

        // R4/R8: maximum rectangle then flush
        put_word(32'hA000_0000);
        put_word(32'h0003_0004);
        put_word(32'h0000_0000);
        tick(1);
        chk("R4", "zero width is 1024", int'(xfer_w), 1024);
        chk("R4", "zero height is 512", int'(xfer_h), 512);
        send_ctl(32'h0100_0000);
        chk("R8", "flush to idle", int'(seq_state), 0);
        chk("R8", "xfer_w cleared", int'(xfer_w), 0);
        chk("R8", "xfer_x cleared", int'(xfer_x), 0);
        chk("R8", "dma_ready after flush", int'(stat_dma_ready), 1);

        // R8: other control codes ignored
        put_word(32'h0200_0000);
        tick(1);
        send_ctl(32'h0200_0000);
        chk("R8", "other code ignored", int'(seq_state), 1);
        send_ctl(32'h0100_0000);
        chk("R8", "flush from wait", int'(seq_state), 0);
        exp_q.push_back(8'h1F);
        put_word(32'h1F00_0000);
        tick(1);
        chk("R8", "runs after flush", int'(cmd_done), 1);

        // R8: buffered words discarded by flush
        exp_q.push_back(8'hC1);
        put_word(32'hC100_0000);
        put_word(32'h0000_0000);
        put_word(32'h0001_0001);
        tick(2);
        chk("R7", "second read parked", int'(seq_state), 3);
        put_word(32'hE500_0000);
        put_word(32'hE600_0000);
        send_ctl(32'h0100_0000);
        chk("R8", "flush from read", int'(seq_state), 0);
        chk("R8", "vram_send off", int'(stat_vram_send), 0);
        tick(4);
        chk("R8", "discarded words never retire", int'(cmd_done), 0);

        // R9: buffer full backpressure
        exp_q.push_back(8'hC2);
        put_word(32'hC200_0000);
        put_word(32'h0000_0000);
        put_word(32'h0001_0001);
        tick(2);
        exp_q.push_back(8'hE1); put_word(32'hE100_0000);
        exp_q.push_back(8'hE2); put_word(32'hE200_0000);
        exp_q.push_back(8'hE3); put_word(32'hE300_0000);
        exp_q.push_back(8'hE4); put_word(32'hE400_0000);
        chk("R9", "ready low when full", int'(gp0_ready), 0);
        gp0_valid = 1'b1;
        gp0_data  = 32'hE700_0000;
        tick(2);
        gp0_valid = 1'b0;
        pulse_rd_done();
        tick(8);
        chk("R9", "drained to idle", int'(seq_state), 0);
        chk("R9", "ready again", int'(gp0_ready), 1);

        tick(3);
        chk("R2", "all expected commands retired", exp_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule